// File: doc/BRIEF.md
# Sequenced Trigger Capture Buffer

This block is a small on-chip logic analyzer. Every rising clock edge it may store one sample of an 8-bit data bus into a circular sample memory. Three single-bit trigger inputs each drive a match unit. A unit matches when its input equals a programmable compare bit. A two-level sequencer fires the trigger only when unit 0 matches and unit 1 matches in a later cycle. A storage-qualification term decides which cycles are written: it is the AND of every match unit selected by a mask.

Software or a controller pulses `arm` and the sequencer goes to its first level. Samples taken before the trigger are kept in the circular memory, up to a settable trigger position. After the trigger the block keeps taking qualified samples until it holds the selected run-time depth. It then raises `done` and stops. A reader then walks the logical addresses 0 to depth-1 through the read port. Address 0 is the oldest stored sample.

States: `S_IDLE` (after reset), `S_LVL1` (waiting for unit 0), `S_LVL2` (waiting for unit 1), `S_POST` (filling after the trigger) and `S_FULL` (capture complete). The transitions are as follows:
- arm moves any state to `S_LVL1`.
- A unit 0 match moves `S_LVL1` to `S_LVL2`.
- A unit 1 match moves `S_LVL2` to `S_POST`. It goes to `S_FULL` instead when that same cycle's write completes the buffer.
- `S_POST` moves to `S_FULL` on the write that completes the buffer.
- `S_IDLE` and `S_FULL` stay where they are until arm.

Top module: `seq_capture`

## Requirements
- R1: After reset `busy`, `triggered` and `done` are all 0.
- R2: A cycle with `arm` high puts the block in the first level from any state, including mid-capture. In the next cycle `busy`=1, `triggered`=0 and `done`=0. Earlier sequencer and buffer progress is discarded. The arm cycle itself stores nothing.
- R3: Match unit i matches in a cycle exactly when `trig_in[i]` equals `match_val[i]`. A compare bit of 0 therefore matches a low input.
- R4: The trigger fires in a cycle where unit 1 matches, only after unit 0 matched in a strictly earlier cycle since the last arm. A unit 1 match before or in the same cycle as the unit 0 match does not fire it. `triggered` goes to 1 in the cycle after the firing cycle.
- R5: A cycle is qualified when every unit whose bit is set in `qual_en` matches. With `qual_en`=0 every cycle is qualified. Only qualified cycles are written.
- R6: With `trig_pos`=0, no sample is stored before the trigger. The stored samples are the first `depth` qualified cycles starting with the firing cycle.
- R7: With `trig_pos`=P>0 the buffer holds the last min(P, n) qualified pre-trigger samples, where n is the number taken. The remaining entries are post-trigger samples from the firing cycle on.
- R8: When the buffer holds `depth` samples, `done` rises and stays high until the next arm. No further writes occur.
- R9: `rd_data` shows the sample at logical index `rd_addr` one clock after the address is applied. Index 0 is the oldest sample.
- R10: The run-time `depth` may take any value from 1 to the maximum of 512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | One-cycle pulse that restarts a capture |
| match_val | input | 3 | Compare bit for each match unit |
| qual_en | input | 3 | Mask of units that take part in storage qualification |
| depth | input | 10 | Number of samples to capture, 1 to 512 |
| trig_pos | input | 9 | Number of pre-trigger samples to keep, less than depth |
| trig_in | input | 3 | Trigger inputs, one per match unit |
| data_in | input | 8 | Sampled data bus |
| rd_addr | input | 9 | Logical read index, 0 is oldest |
| rd_data | output | 8 | Sample at the registered read index |
| busy | output | 1 | Armed and capture not finished |
| triggered | output | 1 | Trigger has fired since the last arm |
| done | output | 1 | Buffer full, capture stopped |

## Verification
The bound checker watches these rules on every cycle:
- arm always restarts the sequencer.
- A write only happens in a qualified cycle.
- No write happens in the pre-trigger phase when the trigger position is 0.
- `triggered` can only rise after a firing cycle.
- `done` stays high with no writes until the next arm.

The bench's scenarios are the only check of the stored content. They compare which samples land in the buffer, how pre-trigger history is trimmed to the trigger position, that the readout starts at the oldest sample, and that an out-of-order unit 1 match is ignored. An independent model of the sequence gives the expected values.

// File: rtl/seqcap_pkg.sv
package seqcap_pkg;
    localparam int NUM_TRIG = 3;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_LVL1 = 3'd1,
        S_LVL2 = 3'd2,
        S_POST = 3'd3,
        S_FULL = 3'd4
    } seq_state_t;
endpackage

// File: rtl/seqcap_match.sv
module seqcap_match
    import seqcap_pkg::*;
(
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [NUM_TRIG-1:0] match_val,
    input  logic [NUM_TRIG-1:0] qual_en,
    output logic [NUM_TRIG-1:0] hit,
    output logic                qual
);
    logic [NUM_TRIG-1:0] pass;

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_unit
        assign hit[i]  = (trig_in[i] == match_val[i]);
        assign pass[i] = hit[i] | ~qual_en[i];
    end

    assign qual = &pass;
endmodule

// File: rtl/seqcap_fsm.sv
module seqcap_fsm
    import seqcap_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [1:0]    hit,
    input  logic          qual,
    input  logic [AW:0]   depth,
    input  logic [AW-1:0] trig_pos,
    output logic          wr_en,
    output logic [AW-1:0] wr_ptr,
    output logic          fire,
    output logic          busy,
    output logic          triggered,
    output logic          done
);
    seq_state_t    st, st_n;
    logic [AW-1:0] pre_cnt;
    logic [AW:0]   post_cnt;
    logic [AW:0]   post_inc;
    logic [AW:0]   need;
    logic          pre_wr, post_wr, last_wr;

    assign post_inc = post_cnt + {{AW{1'b0}}, 1'b1};
    assign need     = depth - {1'b0, pre_cnt};
    assign last_wr  = qual && (post_inc == need);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_n;
    end

    // next state and write strobes
    always_comb begin
        st_n    = st;
        fire    = 1'b0;
        pre_wr  = 1'b0;
        post_wr = 1'b0;
        unique case (st)
            S_IDLE: ;
            S_LVL1: begin
                pre_wr = qual && (trig_pos != '0);
                if (hit[0]) st_n = S_LVL2;
            end
            S_LVL2: begin
                if (hit[1]) begin
                    fire    = 1'b1;
                    post_wr = qual;
                    st_n    = last_wr ? S_FULL : S_POST;
                end else begin
                    pre_wr = qual && (trig_pos != '0);
                end
            end
            S_POST: begin
                post_wr = qual;
                if (last_wr) st_n = S_FULL;
            end
            S_FULL: ;
            default: st_n = S_IDLE;
        endcase
        if (arm) begin
            st_n    = S_LVL1;
            fire    = 1'b0;
            pre_wr  = 1'b0;
            post_wr = 1'b0;
        end
    end

    assign wr_en = pre_wr | post_wr;

    // status outputs
    always_comb begin
        busy      = (st == S_LVL1) || (st == S_LVL2) || (st == S_POST);
        triggered = (st == S_POST) || (st == S_FULL);
        done      = (st == S_FULL);
    end

    // write pointer and sample counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else if (arm) begin
            wr_ptr   <= '0;
            pre_cnt  <= '0;
            post_cnt <= '0;
        end else begin
            if (wr_en)
                wr_ptr <= (({1'b0, wr_ptr} + 1'b1) == depth) ? '0 : wr_ptr + 1'b1;
            if (pre_wr && (pre_cnt != trig_pos))
                pre_cnt <= pre_cnt + 1'b1;
            if (post_wr)
                post_cnt <= post_inc;
        end
    end
endmodule

// File: rtl/seqcap_buf.sv
module seqcap_buf #(
    parameter int DATA_W    = 8,
    parameter int MAX_DEPTH = 512,
    parameter int AW        = $clog2(MAX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [DATA_W-1:0] data_in,
    input  logic [AW:0]       depth,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [MAX_DEPTH];
    logic [AW:0]       raw_idx, phys_idx;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= data_in;
    end

    // the next write slot is the oldest sample once capture stops
    always_comb begin
        raw_idx  = {1'b0, wr_ptr} + {1'b0, rd_addr};
        phys_idx = (raw_idx >= depth) ? raw_idx - depth : raw_idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[phys_idx[AW-1:0]];
    end
endmodule

// File: rtl/seq_capture.sv
module seq_capture
    import seqcap_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int MAX_DEPTH = 512,
    localparam int AW       = $clog2(MAX_DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                arm,
    input  logic [NUM_TRIG-1:0] match_val,
    input  logic [NUM_TRIG-1:0] qual_en,
    input  logic [AW:0]         depth,
    input  logic [AW-1:0]       trig_pos,
    input  logic [NUM_TRIG-1:0] trig_in,
    input  logic [DATA_W-1:0]   data_in,
    input  logic [AW-1:0]       rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                busy,
    output logic                triggered,
    output logic                done
);
    logic [NUM_TRIG-1:0] hit;
    logic                qual;
    logic                wr_en;
    logic                fire;
    logic [AW-1:0]       wr_ptr;

    seqcap_match u_match (
        .trig_in   (trig_in),
        .match_val (match_val),
        .qual_en   (qual_en),
        .hit       (hit),
        .qual      (qual)
    );

    seqcap_fsm #(.AW(AW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .hit       (hit[1:0]),
        .qual      (qual),
        .depth     (depth),
        .trig_pos  (trig_pos),
        .wr_en     (wr_en),
        .wr_ptr    (wr_ptr),
        .fire      (fire),
        .busy      (busy),
        .triggered (triggered),
        .done      (done)
    );

    seqcap_buf #(.DATA_W(DATA_W), .MAX_DEPTH(MAX_DEPTH), .AW(AW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .data_in (data_in),
        .depth   (depth),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/seqcap_chk.sv
module seqcap_chk #(
    parameter int AW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arm,
    input logic          qual,
    input logic          wr_en,
    input logic          fire,
    input logic          busy,
    input logic          triggered,
    input logic          done,
    input logic [AW-1:0] trig_pos
);
    // R2
    arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (busy && !triggered && !done));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done);

    // R8
    done_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en);

    // R5
    qual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> qual);

    // R4
    trig_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(triggered) |-> $past(fire));

    // R6
    pre_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !triggered && !fire) |-> (trig_pos != '0));
endmodule

bind seq_capture seqcap_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .qual      (qual),
    .wr_en     (wr_en),
    .fire      (fire),
    .busy      (busy),
    .triggered (triggered),
    .done      (done),
    .trig_pos  (trig_pos)
);

// File: tb/seq_capture_test.sv
module seq_capture_test;
    localparam int AW = 9;

    typedef struct packed {
        logic [15:0] dep;
        logic [15:0] pos;
        logic [2:0]  qen;
        logic [2:0]  mval;
        logic [15:0] m0;
        logic [15:0] m1;
        logic [15:0] e1;
        logic [3:0]  qper;
        logic [15:0] run;
    } scen_t;

    localparam int NSC = 9;
    localparam scen_t TBL [NSC] = '{
        '{16, 0,   3'b000, 3'b111, 3,   5,   16'hFFFF, 1, 40},   // R6 no history
        '{16, 4,   3'b000, 3'b111, 10,  12,  16'hFFFF, 1, 40},   // R7 history trimmed
        '{8,  6,   3'b000, 3'b111, 1,   3,   16'hFFFF, 1, 30},   // R7 short history
        '{8,  0,   3'b100, 3'b111, 2,   4,   16'hFFFF, 3, 60},   // R5 unit 2 qualifies
        '{8,  2,   3'b100, 3'b010, 5,   9,   16'hFFFF, 2, 60},   // R3 low compare bits, R5
        '{16, 0,   3'b000, 3'b111, 10,  10,  4,        1, 40},   // R4 unit 1 early / same cycle
        '{8,  0,   3'b000, 3'b111, 6,   7,   3,        1, 40},   // R4 early unit 1 then proper
        '{512,100, 3'b000, 3'b111, 200, 300, 16'hFFFF, 1, 760},  // R10 max depth, R7
        '{1,  0,   3'b000, 3'b111, 0,   1,   16'hFFFF, 1, 10}    // R10 depth of one
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [2:0]    match_val = 3'b111;
    logic [2:0]    qual_en = 3'b000;
    logic [AW:0]   depth = 10'd16;
    logic [AW-1:0] trig_pos = '0;
    logic [2:0]    trig_in = 3'b000;
    logic [7:0]    data_in = 8'h00;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;
    logic          busy, triggered, done;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    seq_capture uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .match_val (match_val),
        .qual_en   (qual_en),
        .depth     (depth),
        .trig_pos  (trig_pos),
        .trig_in   (trig_in),
        .data_in   (data_in),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .triggered (triggered),
        .done      (done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm     = 1'b1;
        trig_in = ~match_val;
        @(negedge clk);
        arm     = 1'b0;
    endtask

    // one cycle with chosen events; inputs match exactly where ev is set
    task automatic step(input logic [2:0] ev, input logic [7:0] d);
        trig_in = ev ^ ~match_val;
        data_in = d;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] preq[$];
        logic [7:0] postq[$];
        int         ms;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", 32'(busy), 0);
        check("R1 triggered", 32'(triggered), 0);
        check("R1 done", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after release", 32'({busy, triggered, done}), 0);

        for (int k = 0; k < NSC; k++) begin
            scen_t s = TBL[k];
            depth     = s.dep[AW:0];
            trig_pos  = s.pos[AW-1:0];
            qual_en   = s.qen;
            match_val = s.mval;
            preq.delete();
            postq.delete();
            ms = 0;
            do_arm();
            for (int t = 0; t < int'(s.run); t++) begin
                logic [2:0] ev;
                logic [7:0] d;
                logic       q;
                ev[0] = (t == int'(s.m0));
                ev[1] = (t == int'(s.m1)) || (t == int'(s.e1));
                ev[2] = ((t % int'(s.qper)) == 0);
                d     = 8'(t * 37 + k * 5 + 11);
                q     = &(ev | ~s.qen);
                case (ms)
                    0: begin
                        if (q && s.pos != 0) preq.push_back(d);
                        if (ev[0]) ms = 1;
                    end
                    1: begin
                        if (ev[1]) begin
                            ms = 2;
                            if (q) postq.push_back(d);
                        end else if (q && s.pos != 0) preq.push_back(d);
                    end
                    2: if (q) postq.push_back(d);
                    default: ;
                endcase
                if (preq.size() > int'(s.pos)) void'(preq.pop_front());
                if (ms == 2 && postq.size() == int'(s.dep) - preq.size()) ms = 3;
                step(ev, d);
            end
            // R4 trigger sequence, R8 completion
            check($sformatf("R4 triggered scen %0d", k), 32'(triggered), 32'(ms >= 2));
            check($sformatf("R8 done scen %0d", k), 32'(done), 32'(ms == 3));
            if (ms == 3) begin
                for (int i = 0; i < int'(s.dep); i++) begin
                    logic [7:0] e;
                    e = (i < preq.size()) ? preq[i] : postq[i - preq.size()];
                    rd_addr = AW'(i);
                    @(negedge clk);
                    // R9 oldest-first readout
                    check($sformatf("R9 scen %0d idx %0d", k, i), 32'(rd_data), 32'(e));
                end
            end
        end

        // R2 re-arm mid-sequence returns to level 1
        depth = 10'd4; trig_pos = '0; qual_en = 3'b000; match_val = 3'b111;
        do_arm();
        check("R2 busy after arm", 32'(busy), 1);
        step(3'b001, 8'h10);
        step(3'b000, 8'h11);
        do_arm();
        step(3'b010, 8'h12);
        check("R2 unit 0 history cleared", 32'(triggered), 0);
        step(3'b001, 8'h13);
        step(3'b010, 8'hA1);
        check("R2 fires after fresh sequence", 32'(triggered), 1);
        step(3'b000, 8'hA2);
        step(3'b000, 8'hA3);
        step(3'b000, 8'hA4);
        check("R8 done after four", 32'(done), 1);
        step(3'b000, 8'hEE);
        check("R8 done holds", 32'(done), 1);
        rd_addr = '0;
        @(negedge clk);
        check("R8 first sample not overwritten", 32'(rd_data), 32'h A1);
        rd_addr = 9'd3;
        @(negedge clk);
        check("R8 last sample not overwritten", 32'(rd_data), 32'h A4);
        do_arm();
        check("R2 re-arm clears done", 32'({busy, triggered, done}), 32'b100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule